// File: doc/BRIEF.md
# Iterative Shift Unit with Flags

This unit shifts a byte or word operand left (zeros entering at bit 0) or arithmetically right (copies of the original sign bit entering at the top), one bit position per clock. It is meant to sit in a small 16-bit execute stage. The stage presents the operand, a width select, a direction select and an 8-bit shift count together with a one-cycle `start` strobe. The unit then steps through the shift and raises `done` for one cycle. In that cycle the result, the condition flags and a write mask are valid.

The flags follow the classic accumulator-machine rules. Carry holds the last bit pushed out. Overflow is defined for a single-position left shift and is forced to zero for arithmetic right shifts. Sign, zero and parity come from the final value. A five-bit write mask tells the flag register which flags to update. Flags that are not written keep their previous values on the outputs.

Top module: `iter_shift_unit`

## Requirements
- R1: A left shift moves the operand toward the most significant end and inserts zeros at bit 0. In byte mode (`is_word`=0) only bits 7:0 take part, and `result[15:8]` is always 0.
- R2: An arithmetic right shift (`op_sar`=1) refills the top bit (bit 15 for a word, bit 7 for a byte) with the original sign bit on every step. Rounding is toward minus infinity: byte 0xFB shifted by 1 gives 0xFD.
- R3: `cf` equals the last bit shifted out. For a left shift this is the top bit before the last step. For a right shift it is bit 0 before the last step.
- R4: For a left shift whose effective count is exactly 1, `of` is set when the result's top bit differs from `cf` and cleared otherwise, and `flag_wr[4]` is 1.
- R5: For a left shift whose effective count is greater than 1, overflow is not written (`flag_wr[4]`=0), and the `of` output keeps its previous value.
- R6: For an arithmetic right shift with a nonzero effective count, `of` is written as 0 (`flag_wr[4]`=1).
- R7: With a nonzero effective count, `sf` is the result's top bit and `zf` is 1 when the result is zero. `pf` is 1 when `result[7:0]` holds an even number of ones. Mask bits 3:0 are all 1.
- R8: The effective count is `count[4:0]`, so bits 7:5 are ignored. An effective count of 0 returns the (width-truncated) operand, sets `flag_wr` to 0 and leaves every flag output unchanged.
- R9: `done` is high for exactly one cycle. It is seen N+1 clocks after the edge that accepts `start`, where N is the effective count.
- R10: A `start` that arrives while an operation is in progress is ignored and does not alter that operation's result or timing.
- R11: The flag write mask `flag_wr` uses bit 0 for carry, bit 1 for parity, bit 2 for zero, bit 3 for sign and bit 4 for overflow, and `flag_wr` holds its value until the next `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (accepted only when idle) |
| operand | input | 16 | Value to shift |
| is_word | input | 1 | 1 = 16-bit operand, 0 = 8-bit operand |
| op_sar | input | 1 | 1 = arithmetic right, 0 = left |
| count | input | 8 | Shift count, low 5 bits used |
| result | output | 16 | Shifted value |
| cf | output | 1 | Carry flag |
| of | output | 1 | Overflow flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag |
| flag_wr | output | 5 | Which flags the last operation wrote |
| done | output | 1 | One-cycle completion pulse |

## Verification
On every cycle the assertions check the following:
- `done` is a single-cycle pulse.
- `done` arrives exactly N+1 cycles after an accepted start, which also covers the case of a second start while busy.
- For right shifts, overflow is written as zero.
- For left shifts with a count above one, overflow is left unwritten.
- A zero effective count returns the operand with an empty mask.
- In byte mode the upper byte stays clear.

The actual shifted values, the carry and the single-step overflow need a reference computed in one step, and only the bench's scenarios can show them. The same holds for the sign, zero and parity values and for flags being held across a zero-count operation. The bench sweeps both widths, both directions and every count from 0 to 31.

// File: rtl/shf_pkg.sv
package shf_pkg;
    parameter int DW     = 16;
    parameter int BW     = 8;
    parameter int CIN_W  = 8;
    parameter int CNT_W  = 5;
    parameter int NFLAG  = 5;

    typedef enum logic {SH_LEFT = 1'b0, SH_SAR = 1'b1} shop_e;
    typedef logic [DW-1:0] dword_t;

    // packed order sets the mask bit positions: cry at bit 0, ovf at bit 4
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic par;
        logic cry;
    } flags_t;

    function automatic logic top_bit(dword_t v, logic wide);
        return wide ? v[DW-1] : v[BW-1];
    endfunction

    function automatic dword_t fit(dword_t v, logic wide);
        return wide ? v : {{(DW-BW){1'b0}}, v[BW-1:0]};
    endfunction

    function automatic logic even_par(logic [BW-1:0] b);
        return ~^b;
    endfunction
endpackage

// File: rtl/shf_ctrl.sv
module shf_ctrl
    import shf_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [CW-1:0] cnt_in,
    output logic          busy,
    output logic          load,
    output logic          step_en,
    output logic          finish,
    output logic          single,
    output logic          nonzero
);
    logic [CW-1:0] left_q;

    assign load    = start && !busy;
    assign step_en = busy && (left_q != '0);
    assign finish  = busy && (left_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            left_q  <= '0;
            single  <= 1'b0;
            nonzero <= 1'b0;
        end else if (load) begin
            busy    <= 1'b1;
            left_q  <= cnt_in;
            single  <= (cnt_in == CW'(1));
            nonzero <= (cnt_in != '0);
        end else if (step_en) begin
            left_q  <= left_q - 1'b1;
        end else if (finish) begin
            busy    <= 1'b0;
        end
    end
endmodule

// File: rtl/shf_step.sv
module shf_step
    import shf_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   load,
    input  logic   step_en,
    input  dword_t operand,
    input  logic   wide_in,
    input  shop_e  op_in,
    output dword_t work,
    output logic   cry,
    output logic   wide,
    output shop_e  op
);
    logic   sgn;
    dword_t nxt;
    logic   outbit;

    always_comb begin
        if (op == SH_LEFT) begin
            outbit = top_bit(work, wide);
            nxt    = fit({work[DW-2:0], 1'b0}, wide);
        end else begin
            outbit = work[0];
            if (wide) nxt = {sgn, work[DW-1:1]};
            else      nxt = {{(DW-BW){1'b0}}, sgn, work[BW-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            work <= '0;
            cry  <= 1'b0;
            wide <= 1'b0;
            op   <= SH_LEFT;
            sgn  <= 1'b0;
        end else if (load) begin
            work <= fit(operand, wide_in);
            wide <= wide_in;
            op   <= op_in;
            sgn  <= top_bit(operand, wide_in);
            cry  <= 1'b0;
        end else if (step_en) begin
            work <= nxt;
            cry  <= outbit;
        end
    end
endmodule

// File: rtl/shf_flags.sv
module shf_flags
    import shf_pkg::*;
(
    input  dword_t work,
    input  logic   cry,
    input  logic   wide,
    input  shop_e  op,
    input  logic   single,
    input  logic   nonzero,
    output flags_t val,
    output flags_t wr
);
    logic hi;

    always_comb begin
        hi      = top_bit(work, wide);
        val.cry = cry;
        val.sgn = hi;
        val.zro = (fit(work, wide) == '0);
        val.par = even_par(work[BW-1:0]);
        val.ovf = (op == SH_LEFT) ? (hi ^ cry) : 1'b0;

        wr = '0;
        if (nonzero) begin
            wr.cry = 1'b1;
            wr.par = 1'b1;
            wr.zro = 1'b1;
            wr.sgn = 1'b1;
            wr.ovf = (op == SH_SAR) || single;
        end
    end
endmodule

// File: rtl/iter_shift_unit.sv
module iter_shift_unit
    import shf_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [DW-1:0]    operand,
    input  logic             is_word,
    input  logic             op_sar,
    input  logic [CIN_W-1:0] count,
    output logic [DW-1:0]    result,
    output logic             cf,
    output logic             of,
    output logic             sf,
    output logic             zf,
    output logic             pf,
    output logic [NFLAG-1:0] flag_wr,
    output logic             done
);
    logic   busy, load, step_en, finish, single, nonzero;
    dword_t work;
    logic   cry, wide;
    shop_e  op;
    flags_t fval, fwr;

    logic [NFLAG-1:0] val_v, wr_v, flg_q, wr_q;
    dword_t           res_q;
    logic             done_q;
    logic             unused_cnt_hi;

    assign unused_cnt_hi = ^count[CIN_W-1:CNT_W];

    shf_ctrl #(.CW(CNT_W)) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .cnt_in(count[CNT_W-1:0]),
        .busy(busy), .load(load), .step_en(step_en), .finish(finish),
        .single(single), .nonzero(nonzero)
    );

    shf_step u_step (
        .clk(clk), .rst(rst), .load(load), .step_en(step_en),
        .operand(operand), .wide_in(is_word),
        .op_in(op_sar ? SH_SAR : SH_LEFT),
        .work(work), .cry(cry), .wide(wide), .op(op)
    );

    shf_flags u_flags (
        .work(work), .cry(cry), .wide(wide), .op(op),
        .single(single), .nonzero(nonzero), .val(fval), .wr(fwr)
    );

    assign val_v = fval;
    assign wr_v  = fwr;

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)                   flg_q[i] <= 1'b0;
            else if (finish && wr_v[i]) flg_q[i] <= val_v[i];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q  <= '0;
            wr_q   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= finish;
            if (finish) begin
                res_q <= work;
                wr_q  <= wr_v;
            end
        end
    end

    assign result  = res_q;
    assign flag_wr = wr_q;
    assign done    = done_q;
    assign cf      = flg_q[0];
    assign pf      = flg_q[1];
    assign zf      = flg_q[2];
    assign sf      = flg_q[3];
    assign of      = flg_q[4];
endmodule

// File: rtl/shf_chk.sv
module shf_chk
    import shf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [DW-1:0]    operand,
    input logic             is_word,
    input logic             op_sar,
    input logic [CNT_W-1:0] cnt_lo,
    input logic [DW-1:0]    result,
    input logic             of,
    input logic [NFLAG-1:0] flag_wr,
    input logic             done
);
    logic             idle;
    logic [CNT_W:0]   cyc;
    logic [CNT_W-1:0] lat_cnt;
    logic             lat_sar, lat_word;
    logic [DW-1:0]    lat_opnd;
    logic             take;

    assign take = start && (idle || done);

    always_ff @(posedge clk) begin
        if (rst) begin
            idle     <= 1'b1;
            cyc      <= '0;
            lat_cnt  <= '0;
            lat_sar  <= 1'b0;
            lat_word <= 1'b0;
            lat_opnd <= '0;
        end else if (take) begin
            idle     <= 1'b0;
            cyc      <= '0;
            lat_cnt  <= cnt_lo;
            lat_sar  <= op_sar;
            lat_word <= is_word;
            lat_opnd <= is_word ? operand : {{(DW-BW){1'b0}}, operand[BW-1:0]};
        end else begin
            if (done) idle <= 1'b1;
            if (!idle && !done && cyc != '1) cyc <= cyc + 1'b1;
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9
    AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done |-> (!idle && cyc == ({1'b0, lat_cnt} + 1'b1))); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (done && lat_sar && lat_cnt != '0) |-> (flag_wr[4] && !of)); // R6
    AST_OF_UNWRITTEN: assert property (@(posedge clk) disable iff (rst)
        (done && !lat_sar && lat_cnt > CNT_W'(1)) |-> !flag_wr[4]); // R5
    AST_ZERO_COUNT: assert property (@(posedge clk) disable iff (rst)
        (done && lat_cnt == '0) |-> (flag_wr == '0 && result == lat_opnd)); // R8
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (rst)
        (done && !lat_word) |-> (result[DW-1:BW] == '0)); // R1
    AST_MASK_LOW: assert property (@(posedge clk) disable iff (rst)
        (done && lat_cnt != '0) |-> (flag_wr[3:0] == 4'hF)); // R7
endmodule

bind iter_shift_unit shf_chk u_chk (
    .clk(clk), .rst(rst), .start(start), .operand(operand),
    .is_word(is_word), .op_sar(op_sar), .cnt_lo(count[4:0]),
    .result(result), .of(of), .flag_wr(flag_wr), .done(done)
);

// File: tb/iter_shift_unit_tb.sv
module iter_shift_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [15:0] operand = '0;
    logic        is_word = 1'b0;
    logic        op_sar = 1'b0;
    logic [7:0]  count = '0;
    logic [15:0] result;
    logic        cf, of, sf, zf, pf, done;
    logic [4:0]  flag_wr;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    iter_shift_unit u_dut (
        .clk(clk), .rst(rst), .start(start), .operand(operand),
        .is_word(is_word), .op_sar(op_sar), .count(count),
        .result(result), .cf(cf), .of(of), .sf(sf), .zf(zf), .pf(pf),
        .flag_wr(flag_wr), .done(done)
    );

    task automatic chk(input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Start one operation and wait for done; returns negedges counted.
    task automatic launch(input logic [15:0] x, input logic w, input logic s,
                          input logic [7:0] c, output int k);
        @(negedge clk);
        operand = x; is_word = w; op_sar = s; count = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 1;
        while (!done && k < 40) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic run_op(input logic [15:0] x, input logic w, input logic s,
                          input logic [7:0] c);
        int     n, wd, k, ones;
        longint m, ux, sx, eres, ecf, eof, esf, ezf, epf, ewr;
        logic [4:0] prev;
        n  = int'(c[4:0]);
        wd = w ? 16 : 8;
        m  = (longint'(1) << wd) - 1;
        ux = longint'(x) & m;
        sx = (ux ^ (longint'(1) << (wd-1))) - (longint'(1) << (wd-1));
        prev = {of, sf, zf, pf, cf};
        eres = ux; ecf = 0; eof = 0; ewr = 0;
        if (n != 0 && !s) begin
            eres = (ux << n) & m;
            ecf  = ((ux << (n-1)) >> (wd-1)) & 1;
            eof  = ((eres >> (wd-1)) & 1) ^ ecf;
            ewr  = (n == 1) ? 5'h1F : 5'h0F;
        end else if (n != 0) begin
            eres = (sx >>> n) & m;
            ecf  = (sx >>> (n-1)) & 1;
            eof  = 0;
            ewr  = 5'h1F;
        end
        esf = (eres >> (wd-1)) & 1;
        ezf = (eres == 0) ? 1 : 0;
        ones = 0;
        for (int b = 0; b < 8; b++) ones += int'((eres >> b) & 1);
        epf = (ones % 2 == 0) ? 1 : 0;

        launch(x, w, s, c, k);
        chk("R9", "latency", k, n + 2);
        chk("R11", "mask", flag_wr, ewr);
        if (n == 0) begin
            chk("R8", "result", result, eres);
            chk("R8", "flags held", {of, sf, zf, pf, cf}, prev);
        end else begin
            chk(s ? "R2" : "R1", "result", result, eres);
            chk("R3", "carry", cf, ecf);
            chk("R7", "sign", sf, esf);
            chk("R7", "zero", zf, ezf);
            chk("R7", "parity", pf, epf);
            if (s)           chk("R6", "overflow", of, 0);
            else if (n == 1) chk("R4", "overflow", of, eof);
            else             chk("R5", "overflow held", of, prev[4]);
        end
        @(negedge clk);
        chk("R9", "done single cycle", done, 0);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R9", "reset done", done, 0);
        chk("R11", "reset mask", flag_wr, 0);
        chk("R1", "reset result", result, 0);
    endtask

    task automatic t_directed;
        run_op(16'h00FB, 1'b0, 1'b1, 8'd1);  // R2: -5 >> 1 = 0xFD
        chk("R2", "minus five", result, 16'h00FD);
        run_op(16'h0040, 1'b0, 1'b0, 8'd1);  // R4: 0x80, cf0, of1
        chk("R4", "of set", of, 1);
        run_op(16'h00C0, 1'b0, 1'b0, 8'd1);  // R4: 0x80, cf1, of0
        chk("R4", "of clear", of, 0);
        run_op(16'h4000, 1'b1, 1'b0, 8'd1);
        run_op(16'h8001, 1'b1, 1'b1, 8'd15);
        run_op(16'hABCD, 1'b0, 1'b0, 8'd3);  // R1 byte mode upper zero
        chk("R1", "byte upper", result[15:8], 0);
    endtask

    task automatic t_zero_count;
        run_op(16'h0081, 1'b0, 1'b0, 8'd1);
        run_op(16'h1234, 1'b1, 1'b0, 8'h20); // R8 masked to 0
        run_op(16'h1234, 1'b1, 1'b1, 8'h00);
        run_op(16'h0003, 1'b1, 1'b0, 8'hE1); // R8 masked to 1
        chk("R8", "high count bits ignored", result, 16'h0006);
    endtask

    task automatic t_busy_ignore;
        int k;
        @(negedge clk);
        operand = 16'h0001; is_word = 1'b1; op_sar = 1'b0; count = 8'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        operand = 16'h8000; op_sar = 1'b1; count = 8'd9; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 3;
        while (!done && k < 40) begin
            @(negedge clk);
            k++;
        end
        chk("R10", "latency of first op", k, 5);
        chk("R10", "result of first op", result, 16'h0008);
        @(negedge clk);
    endtask

    task automatic t_sweep;
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 2; s++)
                for (int n = 0; n < 32; n++)
                    for (int r = 0; r < 2; r++)
                        run_op(16'($urandom), w[0], s[0], 8'(n));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_directed();
        t_zero_count();
        t_busy_ignore();
        t_sweep();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1500000;
        total++;
        bad++;
        $display("FAIL watchdog timeout actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule